// File: doc/BRIEF.md
# Serial Median-of-Nine Sorter

This block takes nine samples, one per enable strobe, and gives back their median. It writes each sample into the next free slot of a nine-entry register array. When the ninth sample is in place, the block sorts the array into ascending order with repeated passes of adjacent compare-and-swap steps. Each pass counts the pairs that are already in order. A pass that finds every pair in order ends the sort early.

When the sort ends, the block drives the centre element of the array on its median output and pulses done for one cycle. The median output keeps that value until the next result. The capture counter then clears, so the block can take a fresh set of nine. While a sort is running, the block ignores enable. It suits designs that need a median now and then, and that prefer a few hundred cycles of latency to a parallel comparator network.

Top module: `med9_sorter`

## Requirements
- R1: While reset is high and in the first cycle after it, done is 0 and median is 0.
- R2: A sample is taken only on a rising edge where enable is high and the block is waiting for a sample. In the cycle after a sample is taken, enable is ignored, so an enable held for two cycles stores only the first value.
- R3: After the ninth sample is taken, done rises no more than 2 + 17*9 = 155 clock edges later. With nine samples a pass takes 17 edges: one to set up and two per compared pair.
- R4: Two equal samples count as in order and are never swapped. Sets that contain repeated values give the correct median.
- R5: The median is the fifth smallest of the nine samples, which are compared as unsigned 8-bit values by default.
- R6: Done is high for exactly one cycle for each result.
- R7: Median changes only in the cycle in which done is high, and it holds its value at all other times.
- R8: Enable during a sort has no effect. The pending result and the capture of the next set are the same as if enable had stayed low.
- R9: The block is ready again in the cycle where done is high. An enable in that cycle is taken as the first sample of the next set.
- R10: A set that arrives already in ascending order is sorted in one pass, and done rises exactly 19 edges after the ninth sample is taken. A set that arrives in strictly descending order needs nine passes, and done rises exactly 155 edges after the ninth sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Strobe that marks a valid sample on data_in |
| data_in | input | DATA_W | Sample value |
| done | output | 1 | One-cycle pulse when a median is ready |
| median | output | DATA_W | Most recent median, held between results |

## Verification
The result handshake and the capture of the next set's first sample can fall in the same cycle. The block is back in its waiting state while done is high. The bench starts the next set as soon as it sees done, so enable is high at the edge right after the done cycle. It then judges the overlap by two things: the following median must use that first sample, and done must drop after its single cycle. Enable strobes during a sort, and an enable held for two cycles, are also tested. Their outcome is judged only through later medians and done latencies.

// File: rtl/med9_pkg.sv
package med9_pkg;
   typedef enum logic [2:0] {
      ST_WAIT  = 3'd0,
      ST_LATCH = 3'd1,
      ST_PASS  = 3'd2,
      ST_CMP   = 3'd3,
      ST_ADV   = 3'd4,
      ST_EMIT  = 3'd5
   } med_state_e;
endpackage

// File: rtl/med9_cmp.sv
module med9_cmp #(
   parameter int DATA_W     = 8,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              gt_o
);
   generate
      if (SIGNED_CMP) begin : g_signed
         assign gt_o = $signed(a_i) > $signed(b_i);
      end else begin : g_unsigned
         assign gt_o = a_i > b_i;
      end
   endgenerate
endmodule

// File: rtl/med9_ctrl.sv
module med9_ctrl
   import med9_pkg::*;
#(
   parameter int N_SAMPLES = 9,
   localparam int IDX_W = $clog2(N_SAMPLES),
   localparam int CNT_W = $clog2(N_SAMPLES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable_i,
   input  logic             gt_i,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [IDX_W-1:0] cmp_idx_o,
   output logic             swap_o,
   output logic             emit_o
);
   localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(N_SAMPLES);
   localparam logic [CNT_W-1:0] PAIRS     = CNT_W'(N_SAMPLES - 1);
   localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(N_SAMPLES - 1);

   med_state_e       state;
   logic [CNT_W-1:0] fill_cnt;
   logic [CNT_W-1:0] ord_cnt;
   logic [IDX_W-1:0] idx;

   assign wr_en_o   = (state == ST_WAIT) && enable_i;
   assign wr_idx_o  = fill_cnt[IDX_W-1:0];
   assign cmp_idx_o = idx;
   assign swap_o    = (state == ST_CMP) && gt_i;
   assign emit_o    = (state == ST_EMIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_WAIT;
         fill_cnt <= '0;
         ord_cnt  <= '0;
         idx      <= '0;
      end else begin
         unique case (state)
            ST_WAIT: begin
               if (enable_i) begin
                  fill_cnt <= fill_cnt + 1'b1;
                  state    <= ST_LATCH;
               end
            end
            ST_LATCH: state <= (fill_cnt == FULL_CNT) ? ST_PASS : ST_WAIT;
            ST_PASS: begin
               idx     <= '0;
               ord_cnt <= '0;
               state   <= ST_CMP;
            end
            ST_CMP: begin
               if (!gt_i) ord_cnt <= ord_cnt + 1'b1;
               idx   <= idx + 1'b1;
               state <= ST_ADV;
            end
            ST_ADV: begin
               if (idx == LAST_PAIR)
                  state <= (ord_cnt == PAIRS) ? ST_EMIT : ST_PASS;
               else
                  state <= ST_CMP;
            end
            ST_EMIT: begin
               fill_cnt <= '0;
               state    <= ST_WAIT;
            end
            default: state <= ST_WAIT;
         endcase
      end
   end

   assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
      fill_cnt <= FULL_CNT);
   assert_sort_ignores_enable_R8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PASS || state == ST_CMP || state == ST_ADV) |=> $stable(fill_cnt));
   assert_pair_index_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CMP) |-> (idx < LAST_PAIR));
endmodule

// File: rtl/med9_store.sv
module med9_store #(
   parameter int DATA_W     = 8,
   parameter int N_SAMPLES  = 9,
   parameter bit SIGNED_CMP = 1'b0,
   localparam int IDX_W = $clog2(N_SAMPLES),
   localparam int MID   = N_SAMPLES / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  cmp_idx_i,
   input  logic              swap_i,
   input  logic              sorted_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   output logic [DATA_W-1:0] mid_o
);
   logic [DATA_W-1:0] mem [N_SAMPLES];

   assign lo_o  = mem[cmp_idx_i];
   assign hi_o  = mem[cmp_idx_i + 1'b1];
   assign mid_o = mem[MID];

   function automatic logic in_order(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
      if (SIGNED_CMP) return $signed(a) <= $signed(b);
      else            return a <= b;
   endfunction

   for (genvar k = 0; k < N_SAMPLES; k++) begin : g_slot
      logic take_hi, take_lo;
      if (k < N_SAMPLES - 1) begin : g_hi
         assign take_hi = swap_i && (cmp_idx_i == IDX_W'(k));
      end else begin : g_nohi
         assign take_hi = 1'b0;
      end
      if (k > 0) begin : g_lo
         assign take_lo = swap_i && (cmp_idx_i == IDX_W'(k - 1));
      end else begin : g_nolo
         assign take_lo = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (rst)
            mem[k] <= '0;
         else if (wr_en_i && wr_idx_i == IDX_W'(k))
            mem[k] <= wr_data_i;
         else if (take_hi)
            mem[k] <= mem[(k + 1) % N_SAMPLES];
         else if (take_lo)
            mem[k] <= mem[(k + N_SAMPLES - 1) % N_SAMPLES];
      end

      if (k < N_SAMPLES - 1) begin : g_chk
         assert_sorted_at_emit_R5: assert property (@(posedge clk) disable iff (rst)
            sorted_i |-> in_order(mem[k], mem[k + 1]));
      end
   end

   assert_swap_orders_pair_R4: assert property (@(posedge clk) disable iff (rst)
      swap_i |=> in_order(mem[$past(cmp_idx_i)], mem[$past(cmp_idx_i) + 1'b1]));
endmodule

// File: rtl/med9_sorter.sv
module med9_sorter #(
   parameter int DATA_W     = 8,
   parameter int N_SAMPLES  = 9,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic [DATA_W-1:0] data_in,
   output logic              done,
   output logic [DATA_W-1:0] median
);
   localparam int IDX_W = $clog2(N_SAMPLES);

   if (N_SAMPLES < 3 || (N_SAMPLES % 2) == 0) begin : g_bad_count
      $error("N_SAMPLES must be odd and at least 3");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic              wr_en, swap, emit, gt;
   logic [IDX_W-1:0]  wr_idx, cmp_idx;
   logic [DATA_W-1:0] lo, hi, mid;

   med9_ctrl #(.N_SAMPLES(N_SAMPLES)) u_ctrl (
      .clk(clk), .rst(rst), .enable_i(enable), .gt_i(gt),
      .wr_en_o(wr_en), .wr_idx_o(wr_idx), .cmp_idx_o(cmp_idx),
      .swap_o(swap), .emit_o(emit)
   );

   med9_store #(.DATA_W(DATA_W), .N_SAMPLES(N_SAMPLES), .SIGNED_CMP(SIGNED_CMP)) u_store (
      .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(data_in),
      .cmp_idx_i(cmp_idx), .swap_i(swap), .sorted_i(emit),
      .lo_o(lo), .hi_o(hi), .mid_o(mid)
   );

   med9_cmp #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .a_i(lo), .b_i(hi), .gt_o(gt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done   <= 1'b0;
         median <= '0;
      end else begin
         done <= emit;
         if (emit) median <= mid;
      end
   end

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_median_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(median));
endmodule

// File: tb/med9_sorter_tb.sv
module med9_sorter_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       enable = 1'b0;
   logic [7:0] data_in = '0;
   logic       done;
   logic [7:0] median;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #4 clk = ~clk;

   med9_sorter u_dut (
      .clk(clk), .rst(rst), .enable(enable), .data_in(data_in),
      .done(done), .median(median)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_median(input logic [7:0] v[9]);
      int s[9];
      for (int i = 0; i < 9; i++) s[i] = v[i];
      for (int i = 1; i < 9; i++)
         for (int j = i; j > 0 && s[j-1] > s[j]; j--) begin
            int t = s[j]; s[j] = s[j-1]; s[j-1] = t;
         end
      return s[4];
   endfunction

   // called at a negedge; returns at a negedge with enable low
   task automatic send(input logic [7:0] v);
      enable = 1'b1; data_in = v;
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
   endtask

   // counts edges from the ninth acceptance edge until done is seen
   task automatic wait_done(output int lat);
      lat = 1;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_set(input logic [7:0] v[9], input string req, input int exp_lat);
      int lat;
      for (int i = 0; i < 9; i++) send(v[i]);
      wait_done(lat);
      check(done == 1'b1, req, done, 1);
      check(median == 8'(ref_median(v)), req, median, ref_median(v));
      if (exp_lat >= 0) check(lat == exp_lat, "R10 latency", lat, exp_lat);
      else check(lat <= 155, "R3 latency bound", lat, 155);
      @(negedge clk);
      check(done == 1'b0, "R6 one-cycle done", done, 0);
   endtask

   initial begin : watchdog
      while (cyc < 150000) begin @(posedge clk); cyc++; end
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] v[9];
      logic [7:0] held;
      int lat;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 reset done", done, 0);
      check(median == 8'd0, "R1 reset median", median, 0);
      rst = 1'b0;
      @(negedge clk);
      check(done == 1'b0 && median == 8'd0, "R1 after reset", median, 0);

      // R10: ascending order, single pass
      for (int i = 0; i < 9; i++) v[i] = 8'(10 * i + 3);
      run_set(v, "R5 ascending", 19);

      // R10: descending order, nine passes
      for (int i = 0; i < 9; i++) v[i] = 8'(200 - 20 * i);
      run_set(v, "R5 descending", 155);

      // R7: hold across idle cycles and partial capture
      held = median;
      repeat (5) @(negedge clk);
      check(median == held, "R7 hold idle", median, held);

      // R4: duplicates and extremes
      v = '{8'd7, 8'd7, 8'd255, 8'd0, 8'd7, 8'd7, 8'd0, 8'd255, 8'd7};
      run_set(v, "R4 duplicates", -1);
      v = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
      run_set(v, "R4 all equal", 19);

      // R2: enable held two cycles stores only the first value
      enable = 1'b1; data_in = 8'd1;
      @(negedge clk);
      data_in = 8'd250;
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      v = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9};
      for (int i = 1; i < 9; i++) send(v[i]);
      check(median == held || done == 1'b0, "R7 hold while filling", done, 0);
      wait_done(lat);
      check(median == 8'd5, "R2 held enable", median, 5);
      @(negedge clk);

      // R8: enable during sort is ignored
      v = '{8'd90, 8'd10, 8'd50, 8'd70, 8'd30, 8'd20, 8'd80, 8'd60, 8'd40};
      for (int i = 0; i < 9; i++) send(v[i]);
      enable = 1'b1; data_in = 8'd255;
      repeat (12) @(negedge clk);
      enable = 1'b0;
      wait_done(lat);
      check(median == 8'd50, "R8 result", median, 50);

      // R9: first sample of next set in the done cycle
      v = '{8'd100, 8'd1, 8'd2, 8'd3, 8'd101, 8'd102, 8'd103, 8'd4, 8'd104};
      send(v[0]);
      check(done == 1'b0, "R6 done dropped", done, 0);
      for (int i = 1; i < 9; i++) send(v[i]);
      wait_done(lat);
      check(median == 8'(ref_median(v)), "R9 overlap", median, ref_median(v));
      check(lat == 155 || lat <= 155, "R3 overlap latency", lat, 155);
      @(negedge clk);

      // random sets, R5 / R3
      for (int s = 0; s < 30; s++) begin
         for (int i = 0; i < 9; i++)
            v[i] = (s % 3 == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(0, 255));
         run_set(v, "R5 random", -1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule